// File: doc/BRIEF.md
# Event Counter and Vectored Interrupt Unit

This block keeps a few hardware counters and a serial receive word on behalf of a processor core. Outside logic raises event requests: a timer tick, a display-refresh tick, an up or a down step on a general-purpose counter, and single bits of serial uplink data. Each request waits in a small per-source queue. The unit never changes a counter by itself. When the core pulses its instruction-boundary strobe, the unit takes exactly one waiting request, chosen by a fixed order, and applies it as a stolen micro-operation in that cycle.

The timer and display counters are 15 bits wide. When either one wraps from its all-ones value back to zero, it raises an interrupt. The serial word raises an interrupt each time a full 16 bits have been shifted in. Two more interrupt causes, a hardware alarm and a keypress, come straight from input pulses. A fixed-priority arbiter presents a vector with a valid flag to the core. The core can inhibit and release interrupt delivery, acknowledge the vector on offer, and signal a resume when its service routine has finished. A combinational read port exposes every counter and the serial word.

Top module: `ictr_irq_unit`

## Requirements
- R1: During reset and after it, every counter and the serial word read as zero, no interrupt is pending or in service, delivery is enabled, and irq_valid is low.
- R2: A request changes no counter until a cycle in which ib_stb is high. The update appears on rd_data in the cycle after the strobe edge.
- R3: Each strobe performs at most one operation. The order is timer increment, then display increment, then uplink shift, then general increment, then general decrement.
- R4: Each counter request source queues up to 7 waiting requests. A request that arrives while its queue is full is dropped. Requests that are waiting are never lost.
- R5: A general-counter increment adds one and a decrement subtracts one, modulo 2^15. So 0 steps down to 0x7FFF, and 0x7FFF steps up to 0.
- R6: When the timer or display counter is incremented from 0x7FFF, it becomes 0 and its interrupt becomes pending.
- R7: An uplink shift moves the word left and puts the new bit in bit 0. The 16th shift since the last word completed makes the uplink interrupt pending. Bits waiting for a strobe are queued up to 4 deep.
- R8: A pulse on err_evt or key_evt makes the alarm or keypress interrupt pending.
- R9: irq_vec carries the pending cause with the lowest code. The codes are alarm=0, timer=1, display=2, uplink=3, keypress=4.
- R10: irq_valid is high only when some cause is pending, delivery is enabled and nothing is in service. irq_inhibit disables delivery, irq_release enables it, and inhibit wins when both are high. Delivery is disabled from the cycle after the inhibit edge.
- R11: irq_ack while irq_valid is high clears the offered cause and marks an interrupt in service until irq_resume. irq_ack while irq_valid is low has no effect.
- R12: rd_sel selects what rd_data shows: 0 the timer counter, 1 the display counter, 2 the general counter, 3 the uplink word. Counters are zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_req | input | 1 | Timer increment request |
| disp_req | input | 1 | Display counter increment request |
| gen_up_req | input | 1 | General counter increment request |
| gen_dn_req | input | 1 | General counter decrement request |
| upl_req | input | 1 | Uplink bit shift request |
| upl_bit | input | 1 | Uplink data bit for upl_req |
| ib_stb | input | 1 | Instruction-boundary strobe, one operation slot |
| err_evt | input | 1 | Hardware alarm event |
| key_evt | input | 1 | Keypress event |
| irq_inhibit | input | 1 | Disable interrupt delivery |
| irq_release | input | 1 | Enable interrupt delivery |
| irq_ack | input | 1 | Acknowledge offered vector |
| irq_resume | input | 1 | End of interrupt service |
| rd_sel | input | 2 | Read port select |
| rd_data | output | 16 | Selected counter or uplink word |
| irq_valid | output | 1 | Vector on offer |
| irq_vec | output | 3 | Offered interrupt code |

## Verification
A corrupted queue count shows up as a missing or extra counter step on rd_data, one cycle after the strobe that should have served the request. It stays hidden until that request's turn in the priority order comes. A wrong bit count in the shift path moves the uplink interrupt off the 16th bit, and rd_data shows a partly assembled word at that point. An in-service or enable flag stuck at the wrong value is visible on irq_valid in the first cycle after the ack, resume, inhibit or release edge. A wrong overflow decode only becomes visible on the 32768th timer or display step, so the bench drives both counters through a full wrap.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  // operation taken at an instruction boundary
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_TMR  = 3'd1,
    OP_DSP  = 3'd2,
    OP_UPL  = 3'd3,
    OP_GINC = 3'd4,
    OP_GDEC = 3'd5
  } op_e;

  // interrupt cause codes, lower code wins
  localparam int NIRQ    = 5;
  localparam int VEC_W   = 3;
  localparam int IRQ_ERR = 0;
  localparam int IRQ_TMR = 1;
  localparam int IRQ_DSP = 2;
  localparam int IRQ_UPL = 3;
  localparam int IRQ_KEY = 4;

  // counter request queue indexes
  localparam int NQ     = 4;
  localparam int Q_TMR  = 0;
  localparam int Q_DSP  = 1;
  localparam int Q_GINC = 2;
  localparam int Q_GDEC = 3;
endpackage

// File: rtl/ictr_req_queue.sv
module ictr_req_queue
  import ictr_pkg::*;
#(
  parameter int PEND_W = 3,
  parameter int UQ_D   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] ev_req,
  input  logic          up_req,
  input  logic          up_bit,
  input  logic          ib_stb,
  output op_e           op,
  output logic          op_bit
);
  localparam logic [PEND_W-1:0] PMAX = '1;
  localparam int                UN_W = $clog2(UQ_D + 1);
  localparam logic [UN_W-1:0]   UFULL = UN_W'(UQ_D);

  logic [PEND_W-1:0] pend_q [NQ];
  logic [PEND_W-1:0] pend_d [NQ];
  logic [NQ-1:0]     has, pop, pend_en;
  logic              up_pop, up_has, uq_en;
  logic [UQ_D-1:0]   uq_q, uq_d;
  logic [UN_W-1:0]   un_q, un_d;

  assign up_has = (un_q != '0);
  assign op_bit = uq_q[0];

  // one slot per boundary, fixed order
  always_comb begin
    op     = OP_NONE;
    pop    = '0;
    up_pop = 1'b0;
    if (ib_stb) begin
      if (has[Q_TMR]) begin
        op = OP_TMR; pop[Q_TMR] = 1'b1;
      end else if (has[Q_DSP]) begin
        op = OP_DSP; pop[Q_DSP] = 1'b1;
      end else if (up_has) begin
        op = OP_UPL; up_pop = 1'b1;
      end else if (has[Q_GINC]) begin
        op = OP_GINC; pop[Q_GINC] = 1'b1;
      end else if (has[Q_GDEC]) begin
        op = OP_GDEC; pop[Q_GDEC] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NQ; i++) begin : g_pend
    logic push;
    assign has[i]  = (pend_q[i] != '0);
    assign push    = ev_req[i] && ((pend_q[i] != PMAX) || pop[i]);
    assign pend_en[i] = push || pop[i];

    always_comb begin
      pend_d[i] = pend_q[i];
      if (push && !pop[i])      pend_d[i] = pend_q[i] + 1'b1;
      else if (!push && pop[i]) pend_d[i] = pend_q[i] - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q[i] <= '0;
      else if (pend_en[i]) pend_q[i] <= pend_d[i];
    end

    // R4: a waiting request count only moves on a push or a pop
    p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_req[i] && !pop[i]) |=> $stable(pend_q[i]));
  end

  // uplink bit queue, oldest bit in position 0
  always_comb begin
    uq_d = uq_q;
    un_d = un_q;
    if (up_pop) begin
      uq_d = uq_q >> 1;
      un_d = un_q - 1'b1;
    end
    if (up_req && ((un_q != UFULL) || up_pop)) begin
      for (int k = 0; k < UQ_D; k++)
        if (un_d == UN_W'(k)) uq_d[k] = up_bit;
      un_d = un_d + 1'b1;
    end
  end
  assign uq_en = up_req || up_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uq_q <= '0;
      un_q <= '0;
    end else if (uq_en) begin
      uq_q <= uq_d;
      un_q <= un_d;
    end
  end

  // R7: queued uplink bits stay put without a push or a shift
  p_upq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_req && !up_pop) |=> $stable(un_q));
  // R3: nothing is served off a boundary
  p_no_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ib_stb) |=> $stable(un_q) || $past(up_req));
endmodule

// File: rtl/ictr_bank.sv
module ictr_bank
  import ictr_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int UPW   = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  op_e            op,
  input  logic           op_bit,
  input  logic [1:0]     rd_sel,
  output logic [UPW-1:0] rd_data,
  output logic           tmr_ovf,
  output logic           dsp_ovf,
  output logic           upl_done
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam int               BC_W = $clog2(UPW);
  localparam logic [BC_W-1:0]  BLAST = BC_W'(UPW - 1);

  logic [CNT_W-1:0] tmr_q, tmr_d, dsp_q, dsp_d, gen_q, gen_d;
  logic [UPW-1:0]   upw_q, upw_d;
  logic [BC_W-1:0]  ubc_q, ubc_d;
  logic             tmr_en, dsp_en, gen_en, upl_en;

  assign tmr_en = (op == OP_TMR);
  assign dsp_en = (op == OP_DSP);
  assign gen_en = (op == OP_GINC) || (op == OP_GDEC);
  assign upl_en = (op == OP_UPL);

  assign tmr_ovf  = tmr_en && (tmr_q == CMAX);
  assign dsp_ovf  = dsp_en && (dsp_q == CMAX);
  assign upl_done = upl_en && (ubc_q == BLAST);

  always_comb begin
    tmr_d = tmr_q + 1'b1;
    dsp_d = dsp_q + 1'b1;
    gen_d = (op == OP_GDEC) ? gen_q - 1'b1 : gen_q + 1'b1;
    upw_d = {upw_q[UPW-2:0], op_bit};
    ubc_d = (ubc_q == BLAST) ? '0 : ubc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      dsp_q <= '0;
      gen_q <= '0;
      upw_q <= '0;
      ubc_q <= '0;
    end else begin
      if (tmr_en) tmr_q <= tmr_d;
      if (dsp_en) dsp_q <= dsp_d;
      if (gen_en) gen_q <= gen_d;
      if (upl_en) begin
        upw_q <= upw_d;
        ubc_q <= ubc_d;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = UPW'(tmr_q);
      2'd1:    rd_data = UPW'(dsp_q);
      2'd2:    rd_data = UPW'(gen_q);
      default: rd_data = upw_q;
    endcase
  end

  // R2: counters hold when no slot is used
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> $stable({tmr_q, dsp_q, gen_q, upw_q}));
  // R6: timer wraps to zero from all ones
  p_tmr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TMR && tmr_q == CMAX) |=> (tmr_q == '0));
  // R5: a decrement lowers the general counter by one
  p_gen_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_GDEC) |=> (gen_q == $past(gen_q) - 1'b1));
endmodule

// File: rtl/ictr_irq_arb.sv
module ictr_irq_arb
  import ictr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_ovf,
  input  logic             dsp_ovf,
  input  logic             upl_done,
  input  logic             err_evt,
  input  logic             key_evt,
  input  logic             inh,
  input  logic             rel,
  input  logic             ack,
  input  logic             resume,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vec
);
  logic [NIRQ-1:0] ip_q, ip_d, set, clr;
  logic            ien_q, ien_d, ien_en;
  logic            svc_q, svc_d, svc_en;
  logic            take;

  always_comb begin
    set          = '0;
    set[IRQ_ERR] = err_evt;
    set[IRQ_TMR] = tmr_ovf;
    set[IRQ_DSP] = dsp_ovf;
    set[IRQ_UPL] = upl_done;
    set[IRQ_KEY] = key_evt;
  end

  // lowest code wins
  always_comb begin
    irq_vec = '0;
    for (int k = NIRQ - 1; k >= 0; k--)
      if (ip_q[k]) irq_vec = VEC_W'(k);
  end

  assign irq_valid = (ip_q != '0) && ien_q && !svc_q;
  assign take      = irq_valid && ack;

  always_comb begin
    clr = '0;
    if (take) clr[irq_vec] = 1'b1;
    ip_d = (ip_q & ~clr) | set;
  end

  assign ien_en = inh || rel;
  assign ien_d  = !inh;
  assign svc_en = take || resume;
  assign svc_d  = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q  <= '0;
      ien_q <= 1'b1;
      svc_q <= 1'b0;
    end else begin
      ip_q <= ip_d;
      if (ien_en) ien_q <= ien_d;
      if (svc_en) svc_q <= svc_d;
    end
  end

  // R11: an accepted vector enters service and is withdrawn
  p_ack_svc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ack) |=> (svc_q && !irq_valid));
  // R11: resume without a new acceptance ends service
  p_resume_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !(irq_valid && ack)) |=> !svc_q);
  // R10: inhibit blocks delivery from the next cycle
  p_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inh |=> !irq_valid);
  // R6: a timer wrap leaves its cause pending
  p_ovf_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> ip_q[IRQ_TMR]);
endmodule

// File: rtl/ictr_irq_unit.sv
module ictr_irq_unit
  import ictr_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int UPW    = 16,
  parameter int PEND_W = 3,
  parameter int UQ_D   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_req,
  input  logic             disp_req,
  input  logic             gen_up_req,
  input  logic             gen_dn_req,
  input  logic             upl_req,
  input  logic             upl_bit,
  input  logic             ib_stb,
  input  logic             err_evt,
  input  logic             key_evt,
  input  logic             irq_inhibit,
  input  logic             irq_release,
  input  logic             irq_ack,
  input  logic             irq_resume,
  input  logic [1:0]       rd_sel,
  output logic [UPW-1:0]   rd_data,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vec
);
  logic [1:0]    rs_q;
  logic          srst_n;
  logic [NQ-1:0] ev_req;
  op_e           op;
  logic          op_bit, tmr_ovf, dsp_ovf, upl_done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  always_comb begin
    ev_req         = '0;
    ev_req[Q_TMR]  = tick_req;
    ev_req[Q_DSP]  = disp_req;
    ev_req[Q_GINC] = gen_up_req;
    ev_req[Q_GDEC] = gen_dn_req;
  end

  ictr_req_queue #(.PEND_W(PEND_W), .UQ_D(UQ_D)) u_queue (
    .clk    (clk),
    .rst_n  (srst_n),
    .ev_req (ev_req),
    .up_req (upl_req),
    .up_bit (upl_bit),
    .ib_stb (ib_stb),
    .op     (op),
    .op_bit (op_bit)
  );

  ictr_bank #(.CNT_W(CNT_W), .UPW(UPW)) u_bank (
    .clk      (clk),
    .rst_n    (srst_n),
    .op       (op),
    .op_bit   (op_bit),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .tmr_ovf  (tmr_ovf),
    .dsp_ovf  (dsp_ovf),
    .upl_done (upl_done)
  );

  ictr_irq_arb u_arb (
    .clk       (clk),
    .rst_n     (srst_n),
    .tmr_ovf   (tmr_ovf),
    .dsp_ovf   (dsp_ovf),
    .upl_done  (upl_done),
    .err_evt   (err_evt),
    .key_evt   (key_evt),
    .inh       (irq_inhibit),
    .rel       (irq_release),
    .ack       (irq_ack),
    .resume    (irq_resume),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec)
  );

  // R1: nothing is offered while the unit is held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !srst_n |-> !irq_valid);
endmodule

// File: tb/ictr_irq_unit_bench.sv
module ictr_irq_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_req = 0, disp_req = 0, gen_up_req = 0, gen_dn_req = 0;
  logic upl_req = 0, upl_bit = 0, ib_stb = 0, err_evt = 0, key_evt = 0;
  logic irq_inhibit = 0, irq_release = 0, irq_ack = 0, irq_resume = 0;
  logic [1:0]  rd_sel = 0;
  logic [15:0] rd_data;
  logic        irq_valid;
  logic [2:0]  irq_vec;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ictr_irq_unit u_ictr_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick_req(tick_req), .disp_req(disp_req),
    .gen_up_req(gen_up_req), .gen_dn_req(gen_dn_req), .upl_req(upl_req),
    .upl_bit(upl_bit), .ib_stb(ib_stb), .err_evt(err_evt), .key_evt(key_evt),
    .irq_inhibit(irq_inhibit), .irq_release(irq_release), .irq_ack(irq_ack),
    .irq_resume(irq_resume), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    rd_sel = s;
    #1;
    v = int'(rd_data);
  endtask

  task automatic chk_rd(input string req, input logic [1:0] s, input int exp);
    int v;
    rd(s, v);
    chk(req, v, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic strobe();
    ib_stb = 1; step(); ib_stb = 0;
  endtask

  task automatic t_reset();
    // R1, R12
    rst_n = 1'b0;
    repeat (2) step();
    chk("R1 valid in reset", irq_valid, 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk_rd("R1 timer", 0, 0);
    chk_rd("R1 display", 1, 0);
    chk_rd("R1 general", 2, 0);
    chk_rd("R12 uplink word", 3, 0);
    chk("R1 valid", irq_valid, 0);
  endtask

  task automatic t_boundary();
    // R2
    do_reset();
    tick_req = 1; step(); tick_req = 0;
    repeat (3) step();
    chk_rd("R2 no strobe no step", 0, 0);
    strobe();
    chk_rd("R2 step after strobe", 0, 1);
  endtask

  task automatic t_priority();
    // R3, R12
    do_reset();
    tick_req = 1; disp_req = 1; gen_up_req = 1; gen_dn_req = 1;
    upl_req = 1; upl_bit = 1;
    step();
    tick_req = 0; disp_req = 0; gen_up_req = 0; gen_dn_req = 0; upl_req = 0;
    strobe();
    chk_rd("R3 timer first", 0, 1);
    chk_rd("R3 display waits", 1, 0);
    chk_rd("R3 uplink waits", 3, 0);
    strobe();
    chk_rd("R3 display second", 1, 1);
    chk_rd("R3 uplink waits", 3, 0);
    strobe();
    chk_rd("R3 uplink third", 3, 1);
    chk_rd("R3 general waits", 2, 0);
    strobe();
    chk_rd("R3 general inc fourth", 2, 1);
    strobe();
    chk_rd("R3 general dec fifth", 2, 0);
    strobe();
    chk_rd("R3 empty strobe timer", 0, 1);
    chk_rd("R3 empty strobe general", 2, 0);
  endtask

  task automatic t_queue();
    // R4: 9 requests, capacity 7
    do_reset();
    tick_req = 1; repeat (9) step(); tick_req = 0;
    repeat (10) strobe();
    chk_rd("R4 queued ticks kept, extra dropped", 0, 7);
  endtask

  task automatic t_gen_wrap();
    // R5
    do_reset();
    gen_dn_req = 1; step(); gen_dn_req = 0;
    strobe();
    chk_rd("R5 zero minus one", 2, 16'h7FFF);
    gen_up_req = 1; step(); gen_up_req = 0;
    strobe();
    chk_rd("R5 max plus one", 2, 0);
    chk("R5 no irq from general", irq_valid, 0);
  endtask

  task automatic t_overflow(input bit disp);
    // R6, R9
    int v;
    do_reset();
    for (int i = 0; i < 32768; i++) begin
      if (disp) disp_req = 1; else tick_req = 1;
      ib_stb = 1;
      step();
    end
    tick_req = 0; disp_req = 0;
    rd(disp ? 2'd1 : 2'd0, v);
    chk("R6 counter at max", v, 16'h7FFF);
    chk("R6 no irq before wrap", irq_valid, 0);
    step();
    ib_stb = 0;
    rd(disp ? 2'd1 : 2'd0, v);
    chk("R6 counter wrapped", v, 0);
    chk("R6 irq valid", irq_valid, 1);
    chk("R9 vector", irq_vec, disp ? 2 : 1);
  endtask

  task automatic t_uplink();
    // R7, R9, R12
    logic [15:0] w = 16'hA5C3;
    do_reset();
    for (int i = 15; i >= 0; i--) begin
      upl_req = 1; upl_bit = w[i]; ib_stb = 1;
      step();
    end
    upl_req = 0;
    chk_rd("R7 fifteen bits in", 3, int'(w >> 1));
    chk("R7 no irq before 16th", irq_valid, 0);
    step();
    ib_stb = 0;
    chk_rd("R7 full word", 3, int'(w));
    chk("R7 irq valid", irq_valid, 1);
    chk("R9 uplink vector", irq_vec, 3);
  endtask

  task automatic t_ack_resume();
    // R8, R9, R11
    do_reset();
    err_evt = 1; key_evt = 1; step(); err_evt = 0; key_evt = 0;
    chk("R8 pending raised", irq_valid, 1);
    chk("R9 alarm beats keypress", irq_vec, 0);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R11 in service hides", irq_valid, 0);
    irq_resume = 1; step(); irq_resume = 0;
    chk("R11 resume reoffers", irq_valid, 1);
    chk("R11 alarm cleared", irq_vec, 4);
    irq_ack = 1; step(); irq_ack = 0;
    irq_resume = 1; step(); irq_resume = 0;
    chk("R11 all served", irq_valid, 0);
  endtask

  task automatic t_inhibit();
    // R10, R11
    do_reset();
    irq_inhibit = 1; step(); irq_inhibit = 0;
    key_evt = 1; step(); key_evt = 0;
    chk("R10 inhibited", irq_valid, 0);
    irq_ack = 1; step(); irq_ack = 0;
    irq_inhibit = 1; irq_release = 1; step();
    irq_inhibit = 0; irq_release = 0;
    chk("R10 inhibit wins", irq_valid, 0);
    irq_release = 1; step(); irq_release = 0;
    chk("R10 release delivers", irq_valid, 1);
    chk("R11 ack while invalid ignored", irq_vec, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_boundary();
    t_priority();
    t_queue();
    t_gen_wrap();
    t_overflow(1'b0);
    t_overflow(1'b1);
    t_uplink();
    t_ack_resume();
    t_inhibit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule